// File: doc/BRIEF.md
# Parallel-Port Byte FIFO with DMA Request Handshake

This block sits between the parallel-port protocol engine and an external DMA controller. It holds up to 64 bytes, each carrying a tag flag. On the DMA side it moves data through a 16-bit buffer register, two bytes per acknowledged transfer. One configuration bit selects the direction. In transmit, DMA words enter the buffer, are split into two bytes (low byte first) and queued for the engine. In receive, bytes from the engine are queued and paired into the buffer for the DMA controller to collect.

The DMA request is sticky. Once raised, it holds until a direction-specific release condition is met, the DMA enable is cleared, or the FIFO is cleared. In receive, a byte with its tag set halts the transfer and can raise an interrupt. The CPU can then take the word from the buffer directly. A timeout flushes data that sits below the threshold. The CPU side also reports buffer and FIFO full/empty status and the number of free FIFO entries. In transmit, the CPU can write words into the buffer directly.

Top module: `pp_dma_fifo`

## Requirements
- R1: After reset, `dma_req` and `irq_tag` are low, the buffer is empty, the FIFO is empty and `st_free` reads 64.
- R2: In transmit (`cfg_dir_rx`=0), an acknowledged DMA word is queued as two bytes, bits 7:0 first and bits 15:8 second. The engine receives bytes in the order they were queued.
- R3: In transmit, the request rises when the effective free space is at least 2 and at least `cfg_thresh`. Effective free space is the free entries minus 2 while the buffer holds a word. The request stays high until an acknowledge would leave fewer than 2 effective free entries. A continuous DMA therefore fills the FIFO to exactly 64 bytes without overflow.
- R4: In receive (`cfg_dir_rx`=1), the request rises when the buffer is empty and the FIFO holds at least 2 bytes and at least `cfg_thresh` bytes. The buffer is loaded only while the request is active, with the earlier byte in bits 7:0. `dma_req` is shown to the DMA side only while the buffer holds a word.
- R5: In receive, the request is dropped once the buffer is empty and fewer than two bytes remain in the FIFO. An odd trailing byte stays in the FIFO.
- R6: In receive, loading a pair that contains a tagged byte drops the request on the same edge. The pair stays in the buffer. `irq_tag` is set only if `cfg_int_en` is 1. A `cpu_buf_rd` pulse empties the buffer and clears `irq_tag`.
- R7: In receive, if the FIFO holds at least 2 bytes, no request is active and no byte arrives for `TMO_CYCLES`+1 cycles, the request rises even below the threshold.
- R8: Clearing `cfg_dma_en` drops the request on the next edge. A `cfg_fifo_clr` pulse empties the FIFO and the buffer and drops the request and the interrupt.
- R9: In transmit, with `cfg_buf_wr_en`=1, a `cpu_buf_wr` pulse loads `cpu_buf_wdata` into the buffer when the buffer is empty or draining, and the word is then queued like a DMA word. With `cfg_buf_wr_en`=0 the pulse is ignored.
- R10: `st_free` always equals 64 minus the number of queued bytes.
- R11: In receive, `eng_in_ready` is low while the FIFO is full, and bytes offered then are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dir_rx | input | 1 | 0 transmit (DMA to engine), 1 receive (engine to DMA) |
| cfg_dma_en | input | 1 | DMA request enable |
| cfg_int_en | input | 1 | Tagged-byte interrupt enable |
| cfg_buf_wr_en | input | 1 | Allows CPU writes into the buffer in transmit |
| cfg_thresh | input | 7 | Request threshold in bytes |
| cfg_fifo_clr | input | 1 | Clears FIFO, buffer, request and interrupt |
| cpu_buf_wr | input | 1 | CPU write strobe to the buffer |
| cpu_buf_wdata | input | 16 | CPU write word |
| cpu_buf_rd | input | 1 | CPU read strobe that empties the buffer in receive |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge, one word per cycle |
| dma_wdata | input | 16 | DMA word in transmit |
| buf_rdata | output | 16 | Buffer contents for DMA or CPU in receive |
| eng_in_valid | input | 1 | Engine byte valid (receive) |
| eng_in_data | input | 8 | Engine byte |
| eng_in_tag | input | 1 | Engine byte tag flag |
| eng_in_ready | output | 1 | FIFO can take an engine byte |
| eng_out_valid | output | 1 | Byte available to engine (transmit) |
| eng_out_data | output | 8 | Byte to engine |
| eng_out_tag | output | 1 | Tag flag of byte to engine |
| eng_out_ready | input | 1 | Engine takes the byte |
| st_buf_full | output | 1 | Buffer holds a word |
| st_fifo_empty | output | 1 | FIFO empty |
| st_fifo_full | output | 1 | FIFO full |
| st_free | output | 7 | Free FIFO entries |
| irq_tag | output | 1 | Tagged-byte interrupt |

## Verification
Transmit is driven by a DMA that acknowledges every request while the engine is stalled. This shows that the sticky request stops at exactly 64 bytes, and the later drain shows the low-byte-first order. Receive is fed with an odd-length burst above the threshold to separate the threshold start from the under-two-bytes release. A single late byte then separates the timeout start from the threshold start. A tagged byte placed in the second pair, tried with the interrupt enabled and disabled, separates the stop from the interrupt gating. Overfilling the FIFO, CPU writes with the write enable off and on, and enable and clear pulses in the middle of a request cover the remaining edges.

// File: rtl/pp_fifo_pkg.sv
package pp_fifo_pkg;

    typedef struct packed {
        logic       tag;
        logic [7:0] data;
    } pp_entry_t;

    typedef struct packed {
        logic        full;
        logic [15:0] word;
    } pp_buf_t;

    function automatic pp_entry_t mk_entry(input logic tag, input logic [7:0] data);
        pp_entry_t e;
        e.tag  = tag;
        e.data = data;
        return e;
    endfunction

    function automatic logic [15:0] pair_word(input pp_entry_t first, input pp_entry_t second);
        return {second.data, first.data};
    endfunction

endpackage

// File: rtl/pp_byte_fifo.sv
module pp_byte_fifo
    import pp_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic [1:0]           push_n,
    input  pp_entry_t [1:0]      wr_e,
    input  logic [1:0]           pop_n,
    output pp_entry_t            head0,
    output pp_entry_t            head1,
    output logic [CW-1:0]        level
);
    pp_entry_t      mem [DEPTH];
    logic [PW-1:0]  wp;
    logic [PW-1:0]  rp;

    always_ff @(posedge clk) begin
        for (int l = 0; l < 2; l++) begin
            if (2'(l) < push_n) begin
                mem[wp + PW'(l)] <= wr_e[l];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            wp    <= wp + PW'(push_n);
            rp    <= rp + PW'(pop_n);
            level <= level + CW'(push_n) - CW'(pop_n);
        end
    end

    assign head0 = mem[rp];
    assign head1 = mem[rp + PW'(1)];

endmodule

// File: rtl/pp_rx_timeout.sv
module pp_rx_timeout #(
    parameter int TMO_W = 16,
    parameter logic [TMO_W-1:0] TMO_LOAD = '1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic armed,
    input  logic restart,
    output logic fire
);
    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr || !armed || restart) begin
            cnt <= TMO_LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - TMO_W'(1);
        end
    end

    assign fire = armed && (cnt == '0);

endmodule

// File: rtl/pp_req_ctrl.sv
module pp_req_ctrl #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          dma_en,
    input  logic          dir_rx,
    input  logic [CW-1:0] thresh,
    input  logic [CW-1:0] level,
    input  logic          buf_full,
    input  logic          ack_ok,
    input  logic          load,
    input  logic          load_tag,
    input  logic          cpu_rd,
    input  logic          tmo_fire,
    output logic          req
);
    int   eff_free;
    int   lvl;
    logic req_nx;

    always_comb begin
        lvl      = int'(level);
        eff_free = DEPTH - lvl - (buf_full ? 2 : 0);
        if (!dma_en) begin
            req_nx = 1'b0;
        end else if (!dir_rx) begin
            if (req) req_nx = (eff_free - (ack_ok ? 2 : 0)) >= 2;
            else     req_nx = (eff_free >= 2) && (eff_free >= int'(thresh));
        end else begin
            if (req && load)
                req_nx = !load_tag;
            else if (req)
                req_nx = !((!buf_full || ack_ok || cpu_rd) && lvl < 2);
            else
                req_nx = !buf_full && lvl >= 2 && (lvl >= int'(thresh) || tmo_fire);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) req <= 1'b0;
        else            req <= req_nx;
    end

endmodule

// File: rtl/pp_dma_fifo.sv
module pp_dma_fifo
    import pp_fifo_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int TMO_W      = 16,
    parameter int TMO_CYCLES = 65535,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_dir_rx,
    input  logic          cfg_dma_en,
    input  logic          cfg_int_en,
    input  logic          cfg_buf_wr_en,
    input  logic [CW-1:0] cfg_thresh,
    input  logic          cfg_fifo_clr,
    input  logic          cpu_buf_wr,
    input  logic [15:0]   cpu_buf_wdata,
    input  logic          cpu_buf_rd,
    output logic          dma_req,
    input  logic          dma_ack,
    input  logic [15:0]   dma_wdata,
    output logic [15:0]   buf_rdata,
    input  logic          eng_in_valid,
    input  logic [7:0]    eng_in_data,
    input  logic          eng_in_tag,
    output logic          eng_in_ready,
    output logic          eng_out_valid,
    output logic [7:0]    eng_out_data,
    output logic          eng_out_tag,
    input  logic          eng_out_ready,
    output logic          st_buf_full,
    output logic          st_fifo_empty,
    output logic          st_fifo_full,
    output logic [CW-1:0] st_free,
    output logic          irq_tag
);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    pp_buf_t          bufr;
    pp_entry_t        head0, head1;
    pp_entry_t [1:0]  wr_e;
    logic [CW-1:0]    level;
    logic [1:0]       push_n, pop_n;
    logic             req_q, ack_ok, drain, cpu_wr_ok, eng_pop;
    logic             eng_push, load, load_tag, cpu_rd, tmo_fire, irq_q;

    assign st_free  = FULL_LVL - level;
    assign dma_req  = req_q && (!cfg_dir_rx || bufr.full);
    assign ack_ok   = dma_ack && dma_req;

    // transmit path: buffer splits into two bytes, engine pops one per cycle
    assign drain     = !cfg_dir_rx && bufr.full && (st_free >= CW'(2));
    assign cpu_wr_ok = !cfg_dir_rx && cfg_buf_wr_en && cpu_buf_wr && !ack_ok
                       && (!bufr.full || drain);
    assign eng_pop   = !cfg_dir_rx && eng_out_ready && (level != '0);

    // receive path: engine pushes one byte, buffer takes a pair under request
    assign eng_push  = cfg_dir_rx && eng_in_valid && (level != FULL_LVL);
    assign load      = cfg_dir_rx && req_q && (!bufr.full || ack_ok) && (level >= CW'(2));
    assign load_tag  = head0.tag || head1.tag;
    assign cpu_rd    = cfg_dir_rx && cpu_buf_rd && bufr.full;

    always_comb begin
        wr_e[0] = drain ? mk_entry(1'b0, bufr.word[7:0]) : mk_entry(eng_in_tag, eng_in_data);
        wr_e[1] = mk_entry(1'b0, bufr.word[15:8]);
        push_n  = drain ? 2'd2 : (eng_push ? 2'd1 : 2'd0);
        pop_n   = load  ? 2'd2 : (eng_pop  ? 2'd1 : 2'd0);
    end

    pp_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .clr    (cfg_fifo_clr),
        .push_n (push_n),
        .wr_e   (wr_e),
        .pop_n  (pop_n),
        .head0  (head0),
        .head1  (head1),
        .level  (level)
    );

    pp_rx_timeout #(.TMO_W(TMO_W), .TMO_LOAD(TMO_W'(TMO_CYCLES))) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .clr     (cfg_fifo_clr),
        .armed   (cfg_dir_rx && (level != '0) && !req_q),
        .restart (eng_push),
        .fire    (tmo_fire)
    );

    pp_req_ctrl #(.DEPTH(DEPTH)) u_req (
        .clk      (clk),
        .rst      (rst),
        .clr      (cfg_fifo_clr),
        .dma_en   (cfg_dma_en),
        .dir_rx   (cfg_dir_rx),
        .thresh   (cfg_thresh),
        .level    (level),
        .buf_full (bufr.full),
        .ack_ok   (ack_ok),
        .load     (load),
        .load_tag (load_tag),
        .cpu_rd   (cpu_rd),
        .tmo_fire (tmo_fire),
        .req      (req_q)
    );

    always_ff @(posedge clk) begin
        if (rst || cfg_fifo_clr) begin
            bufr  <= '0;
            irq_q <= 1'b0;
        end else begin
            if (!cfg_dir_rx) begin
                if (ack_ok)         bufr <= '{full: 1'b1, word: dma_wdata};
                else if (cpu_wr_ok) bufr <= '{full: 1'b1, word: cpu_buf_wdata};
                else if (drain)     bufr.full <= 1'b0;
            end else begin
                if (load)                 bufr <= '{full: 1'b1, word: pair_word(head0, head1)};
                else if (ack_ok || cpu_rd) bufr.full <= 1'b0;
            end
            if (load && load_tag && cfg_int_en) irq_q <= 1'b1;
            else if (cpu_rd)                    irq_q <= 1'b0;
        end
    end

    assign buf_rdata     = bufr.word;
    assign st_buf_full   = bufr.full;
    assign st_fifo_empty = (level == '0);
    assign st_fifo_full  = (level == FULL_LVL);
    assign eng_in_ready  = cfg_dir_rx && (level != FULL_LVL);
    assign eng_out_valid = !cfg_dir_rx && (level != '0);
    assign eng_out_data  = head0.data;
    assign eng_out_tag   = head0.tag;
    assign irq_tag       = irq_q;

endmodule

// File: rtl/pp_dma_fifo_chk.sv
module pp_dma_fifo_chk #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_dir_rx,
    input logic          cfg_dma_en,
    input logic          cfg_int_en,
    input logic          cfg_fifo_clr,
    input logic          dma_req,
    input logic          eng_in_ready,
    input logic          st_buf_full,
    input logic [CW-1:0] st_free,
    input logic          irq_tag
);
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (st_free == CW'(DEPTH) && !dma_req && !irq_tag && !st_buf_full));

    a_r8_enable_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_dma_en |=> !dma_req);

    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        cfg_fifo_clr |=> (st_free == CW'(DEPTH) && !st_buf_full && !dma_req && !irq_tag));

    a_r6_irq_gated: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_tag) |-> $past(cfg_int_en));

    a_r11_full_stall: assert property (@(posedge clk) disable iff (rst)
        (st_free == '0) |-> !eng_in_ready);

    a_r3_tx_room: assert property (@(posedge clk) disable iff (rst)
        (!cfg_dir_rx && $stable(cfg_dir_rx) && dma_req) |-> (st_free >= CW'(2)));

endmodule

bind pp_dma_fifo pp_dma_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_dir_rx   (cfg_dir_rx),
    .cfg_dma_en   (cfg_dma_en),
    .cfg_int_en   (cfg_int_en),
    .cfg_fifo_clr (cfg_fifo_clr),
    .dma_req      (dma_req),
    .eng_in_ready (eng_in_ready),
    .st_buf_full  (st_buf_full),
    .st_free      (st_free),
    .irq_tag      (irq_tag)
);

// File: tb/pp_dma_fifo_tb.sv
module pp_dma_fifo_tb;
    localparam int DEPTH = 64;
    localparam int CW    = 7;
    localparam int TMO   = 20;

    logic clk = 0, rst = 1;
    logic cfg_dir_rx = 0, cfg_dma_en = 0, cfg_int_en = 0, cfg_buf_wr_en = 0, cfg_fifo_clr = 0;
    logic [CW-1:0] cfg_thresh = 7'd8;
    logic cpu_buf_wr = 0, cpu_buf_rd = 0, dma_ack = 0;
    logic [15:0] cpu_buf_wdata = 0, dma_wdata = 0;
    logic eng_in_valid = 0, eng_in_tag = 0, eng_out_ready = 0;
    logic [7:0] eng_in_data = 0;
    logic dma_req, eng_in_ready, eng_out_valid, eng_out_tag;
    logic st_buf_full, st_fifo_empty, st_fifo_full, irq_tag;
    logic [15:0] buf_rdata;
    logic [7:0] eng_out_data;
    logic [CW-1:0] st_free;

    int n_chk = 0, n_fail = 0;
    string phase = "R1";
    bit cmp_en = 0, auto_ack = 0;
    logic [15:0] tx_word = 16'h0100;
    logic [15:0] rxw[$];
    logic [7:0]  txb[$];

    always #10 clk = ~clk;

    pp_dma_fifo #(.DEPTH(DEPTH), .TMO_W(16), .TMO_CYCLES(TMO)) u_dut (
        .clk(clk), .rst(rst), .cfg_dir_rx(cfg_dir_rx), .cfg_dma_en(cfg_dma_en),
        .cfg_int_en(cfg_int_en), .cfg_buf_wr_en(cfg_buf_wr_en), .cfg_thresh(cfg_thresh),
        .cfg_fifo_clr(cfg_fifo_clr), .cpu_buf_wr(cpu_buf_wr), .cpu_buf_wdata(cpu_buf_wdata),
        .cpu_buf_rd(cpu_buf_rd), .dma_req(dma_req), .dma_ack(dma_ack), .dma_wdata(dma_wdata),
        .buf_rdata(buf_rdata), .eng_in_valid(eng_in_valid), .eng_in_data(eng_in_data),
        .eng_in_tag(eng_in_tag), .eng_in_ready(eng_in_ready), .eng_out_valid(eng_out_valid),
        .eng_out_data(eng_out_data), .eng_out_tag(eng_out_tag), .eng_out_ready(eng_out_ready),
        .st_buf_full(st_buf_full), .st_fifo_empty(st_fifo_empty), .st_fifo_full(st_fifo_full),
        .st_free(st_free), .irq_tag(irq_tag)
    );

    // ---------------- behavioural reference model ----------------
    logic [8:0]  mq[$];
    logic [15:0] m_buf = 0;
    bit m_full = 0, m_req = 0, m_irq = 0;
    int m_tmo = TMO;

    always @(posedge clk) begin : model
        int cnt, fr, eff;
        bit ackok, drain, cwr, pop, push, load, ltag, crd, nreq, fire;
        cnt = mq.size();
        fr  = DEPTH - cnt;
        ltag = 0;
        if (rst || cfg_fifo_clr) begin
            mq.delete(); m_full = 0; m_buf = 0; m_req = 0; m_irq = 0; m_tmo = TMO;
        end else if (!cfg_dir_rx) begin
            ackok = dma_ack && m_req;
            eff   = fr - (m_full ? 2 : 0);
            drain = m_full && fr >= 2;
            pop   = eng_out_ready && cnt > 0;
            cwr   = cfg_buf_wr_en && cpu_buf_wr && !ackok && (!m_full || drain);
            if (!cfg_dma_en) nreq = 0;
            else if (m_req)  nreq = (eff - (ackok ? 2 : 0)) >= 2;
            else             nreq = (eff >= 2) && (eff >= int'(cfg_thresh));
            if (pop) void'(mq.pop_front());
            if (drain) begin
                mq.push_back({1'b0, m_buf[7:0]});
                mq.push_back({1'b0, m_buf[15:8]});
            end
            if (ackok)      begin m_buf = dma_wdata;     m_full = 1; end
            else if (cwr)   begin m_buf = cpu_buf_wdata; m_full = 1; end
            else if (drain) m_full = 0;
            m_req = nreq;
            m_tmo = TMO;
        end else begin
            ackok = dma_ack && m_req && m_full;
            push  = eng_in_valid && cnt < DEPTH;
            load  = m_req && (!m_full || ackok) && cnt >= 2;
            crd   = cpu_buf_rd && m_full;
            fire  = (m_tmo == 0) && cnt > 0 && !m_req;
            if (load) ltag = mq[0][8] | mq[1][8];
            if (!cfg_dma_en)       nreq = 0;
            else if (m_req && load) nreq = !ltag;
            else if (m_req)        nreq = !((!m_full || ackok || crd) && cnt < 2);
            else                   nreq = !m_full && cnt >= 2 && (cnt >= int'(cfg_thresh) || fire);
            if (load) begin
                m_buf  = {mq[1][7:0], mq[0][7:0]};
                m_full = 1;
                void'(mq.pop_front());
                void'(mq.pop_front());
            end else if (ackok || crd) m_full = 0;
            if (load && ltag && cfg_int_en) m_irq = 1;
            else if (crd)                   m_irq = 0;
            if (push) mq.push_back({eng_in_tag, eng_in_data});
            if (push || cnt == 0 || m_req) m_tmo = TMO;
            else if (m_tmo != 0)           m_tmo = m_tmo - 1;
            m_req = nreq;
        end
    end

    task automatic cmp(input string fld, input int act, input int exp);
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", phase, fld, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            bit mreq_o;
            mreq_o = m_req && (!cfg_dir_rx || m_full);
            n_chk++;
            cmp("dma_req", int'(dma_req), int'(mreq_o));
            cmp("st_free R10", int'(st_free), DEPTH - mq.size());
            cmp("st_buf_full", int'(st_buf_full), int'(m_full));
            cmp("irq_tag", int'(irq_tag), int'(m_irq));
            cmp("eng_in_ready", int'(eng_in_ready), int'(cfg_dir_rx && mq.size() < DEPTH));
            cmp("eng_out_valid", int'(eng_out_valid), int'(!cfg_dir_rx && mq.size() > 0));
            if (m_full) cmp("buf_rdata", int'(buf_rdata), int'(m_buf));
            if (!cfg_dir_rx && mq.size() > 0) cmp("eng_out_data", int'(eng_out_data), int'(mq[0][7:0]));
        end
    end

    // DMA controller and engine sink
    always @(negedge clk) begin
        dma_ack = 0;
        if (auto_ack && dma_req) begin
            dma_ack = 1;
            if (cfg_dir_rx) rxw.push_back(buf_rdata);
            else begin
                dma_wdata = tx_word;
                tx_word   = tx_word + 16'h0202;
            end
        end
        if (eng_out_ready && eng_out_valid) txb.push_back(eng_out_data);
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_bytes(input int n, input logic [7:0] base, input int tag_at);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!eng_in_ready) begin
                eng_in_valid = 0;
                while (!eng_in_ready) @(negedge clk);
            end
            eng_in_valid = 1;
            eng_in_data  = base + 8'(i);
            eng_in_tag   = (i == tag_at);
        end
        @(negedge clk);
        eng_in_valid = 0;
        eng_in_tag   = 0;
    endtask

    task automatic fifo_clear();
        @(negedge clk); cfg_fifo_clr = 1;
        @(negedge clk); cfg_fifo_clr = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired in phase %s", phase);
        finish_run();
    end

    initial begin : main
        cyc(3);
        rst = 0;
        cmp_en = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 st_free", int'(st_free), 64);
        chk("R1 dma_req", int'(dma_req), 0);
        chk("R1 buf/irq", int'(st_buf_full || irq_tag), 0);

        // R2/R3: transmit fill with stalled engine
        phase = "R3";
        cfg_dir_rx = 0; cfg_thresh = 7'd8; cfg_dma_en = 1; auto_ack = 1;
        cyc(120);
        chk("R3 fifo filled exactly", int'(st_free), 0);
        chk("R3 request released", int'(dma_req), 0);
        chk("R3 full flag", int'(st_fifo_full), 1);
        phase = "R8";
        cfg_dma_en = 0; auto_ack = 0;
        phase = "R2";
        eng_out_ready = 1;
        cyc(80);
        eng_out_ready = 0;
        chk("R2 bytes drained", txb.size(), 64);
        begin
            int bad;
            bad = 0;
            foreach (txb[i]) if (txb[i] != 8'(i)) bad++;
            chk("R2 low byte first order", bad, 0);
        end

        // R9: CPU writes into buffer
        phase = "R9";
        @(negedge clk); cfg_buf_wr_en = 0; cpu_buf_wr = 1; cpu_buf_wdata = 16'hBBAA;
        @(negedge clk); cpu_buf_wr = 0;
        cyc(3);
        chk("R9 ignored when disabled", int'(st_free), 64);
        @(negedge clk); cfg_buf_wr_en = 1; cpu_buf_wr = 1;
        @(negedge clk); cpu_buf_wr = 0;
        cyc(3);
        chk("R9 written word queued", int'(st_free), 62);
        chk("R9 low byte at head", int'(eng_out_data), 8'hAA);
        cfg_buf_wr_en = 0;
        phase = "R8";
        fifo_clear();
        @(negedge clk);
        chk("R8 clear empties", int'(st_free), 64);

        // R4/R5: receive threshold start and under-two release
        phase = "R4";
        cfg_dir_rx = 1; cfg_thresh = 7'd6; cfg_dma_en = 1; cfg_int_en = 1; auto_ack = 1;
        push_bytes(9, 8'h10, -1);
        phase = "R5";
        cyc(100);
        chk("R5 words collected", rxw.size(), 4);
        chk("R5 odd byte left", int'(st_free), 63);
        chk("R5 request released", int'(dma_req), 0);
        begin
            int bad;
            bad = 0;
            foreach (rxw[i]) if (rxw[i] != {8'h11 + 8'(2*i), 8'h10 + 8'(2*i)}) bad++;
            chk("R4 earlier byte in low half", bad, 0);
        end

        // R7: timeout below threshold
        phase = "R7";
        push_bytes(1, 8'h19, -1);
        cyc(15);
        chk("R7 no request before timeout", int'(rxw.size()), 4);
        cyc(60);
        chk("R7 timeout flushed pair", rxw.size(), 5);
        if (rxw.size() == 5) chk("R7 flushed word", int'(rxw[4]), 16'h1918);
        chk("R7 fifo empty", int'(st_fifo_empty), 1);

        // R6: tagged byte stops transfer, interrupt enabled
        phase = "R6";
        rxw.delete();
        cfg_thresh = 7'd4;
        push_bytes(4, 8'h40, 2);
        cyc(10);
        chk("R6 one word before tag", rxw.size(), 1);
        chk("R6 request dropped", int'(dma_req), 0);
        chk("R6 irq raised", int'(irq_tag), 1);
        chk("R6 tagged pair held", int'(buf_rdata), 16'h4342);
        @(negedge clk); cpu_buf_rd = 1;
        @(negedge clk); cpu_buf_rd = 0;
        @(negedge clk);
        chk("R6 cpu read clears irq", int'(irq_tag), 0);
        chk("R6 cpu read empties buffer", int'(st_buf_full), 0);
        // interrupt disabled
        cfg_int_en = 0;
        rxw.delete();
        push_bytes(4, 8'h50, 3);
        cyc(10);
        chk("R6 no irq when disabled", int'(irq_tag), 0);
        chk("R6 tagged pair still held", int'(st_buf_full), 1);
        phase = "R8";
        fifo_clear();
        @(negedge clk);
        chk("R8 clear drops buffer", int'(st_buf_full), 0);

        // R8: enable cleared while request held
        auto_ack = 0; cfg_dma_en = 0;
        push_bytes(8, 8'h60, -1);
        @(negedge clk); cfg_dma_en = 1;
        cyc(4);
        chk("R8 request up while held", int'(dma_req), 1);
        cfg_dma_en = 0;
        cyc(1);
        chk("R8 enable off drops request", int'(dma_req), 0);
        fifo_clear();

        // R11: overfill in receive
        phase = "R11";
        for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            eng_in_valid = 1; eng_in_data = 8'(i);
        end
        @(negedge clk); eng_in_valid = 0;
        chk("R11 fifo full", int'(st_free), 0);
        chk("R11 ready low", int'(eng_in_ready), 0);
        phase = "R8";
        fifo_clear();
        @(negedge clk);
        chk("R8 clear after full", int'(st_free), 64);

        cyc(5);
        finish_run();
    end

endmodule